// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This block fills a register file from an external serial EEPROM that speaks the common three-wire serial protocol with a chip select. It produces the serial clock, the chip select and the serial command line, and it samples the serial data line coming back from the device. A load begins by itself when reset is released and again whenever the host pulses the reload request. A request that arrives during a load waits and is served when that load ends.

Every 16-bit EEPROM word is fetched in its own read transaction: the command bits 1, 1, 0, then the word address MSB first, then one probe bit, then sixteen data bits MSB first. Two consecutive EEPROM words form one 32-bit register, with the even word as the upper half. The probe bit of the first transaction tells whether a device is fitted, since an empty socket reads as 1. A device whose first 33 data bits are all ones is treated as blank. In both of those cases nothing is written, so the register defaults stay in place.

While a load runs, `busy` is high so that slave accesses can be answered with retry. `cfg_valid` reports that the last load found a programmed device. Part sizes of 2 Kbit and 4 Kbit are both covered by the default 8-bit word address.

Top module: `secfg_loader`

## Requirements
- R1: `ee_sk` has a period of DIV system clocks (default 132): low for the first DIV/2 clocks of each serial period and high for the second half. `ee_do` changes only while `ee_sk` is low, and `ee_di` is sampled at the rising edge of `ee_sk`.
- R2: In reset, `busy`, `ee_cs`, `ee_sk`, `cfg_wr_en` and `cfg_valid` are 0. The first system clock after reset is released starts a load, so `busy` is 1 one cycle after `rst` falls.
- R3: A one-cycle `reload_req` pulse while idle starts a load two clocks later. A pulse during a load is held, and the next load starts one cycle after `busy` falls, leaving `busy` low for exactly one cycle. Without a request, no load starts.
- R4: Each transaction raises `ee_cs` and sends 1, 1, 0 and then an AW-bit word address, MSB first. Words are read in ascending address order from 0 to 2*NREG-1.
- R5: Between two transactions of one load, `ee_cs` is low for exactly one serial period, and `ee_sk` stays low during that period.
- R6: The bit sampled in the serial period right after the last address bit of the first transaction is the presence probe. If it is 1, the load ends with no register write and `cfg_valid` at 0. `busy` lasts (AW+4)*DIV clocks, which is within 13 serial periods.
- R7: If the first 33 data bits read (words 0 and 1 and the MSB of word 2) are all ones, the load ends with no write and `cfg_valid` at 0. `busy` lasts (2*(AW+21)+AW+5)*DIV clocks. Data after bit 33 does not matter.
- R8: For a programmed device, exactly NREG writes are made, with indices ascending from 0, and the data of register i is {word 2i, word 2i+1}. `cfg_valid` ends at 1.
- R9: `cfg_wr_en` is a one-cycle strobe. It is only asserted while `busy` and `cfg_valid` are both 1, and `cfg_wr_idx` is always below NREG.
- R10: `cfg_valid` is cleared when a load starts. A full load keeps `busy` high for 2*NREG*(AW+21)*DIV clocks.
- R11: A device whose first 32 data bits are ones but whose 33rd bit is 0 counts as programmed, and register 0 then receives 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reload_req | input | 1 | One-cycle pulse requesting a new load |
| ee_di | input | 1 | Serial data from the EEPROM (reads as 1 when no device is fitted) |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_do | output | 1 | Serial command/address to the EEPROM |
| cfg_wr_en | output | 1 | Register write strobe |
| cfg_wr_idx | output | $clog2(NREG) | Register index being written |
| cfg_wr_data | output | 32 | Assembled register value |
| busy | output | 1 | Load in progress; slave accesses should retry |
| cfg_valid | output | 1 | Last load found a programmed device |

## Verification
`busy` rises one clock after reset is released and two clocks after an idle reload pulse. The bench therefore samples on the falling clock edge and checks `busy` at exactly those samples. A write strobe appears one clock after the system clock that ends the last data period of an odd word, or after the period holding data bit 33. The bench records every strobe on the falling edge of that cycle and compares the whole image against words it generated itself once `busy` has dropped. Load length, serial period, high time and chip-select gap are measured in whole system clocks and compared against closed-form counts in DIV and AW. The bench uses a small divider so that many full loads fit in the run.

// File: rtl/secfg_pkg.sv
package secfg_pkg;

    typedef enum logic {
        LD_IDLE = 1'b0,
        LD_RUN  = 1'b1
    } ld_state_e;

    typedef enum logic [2:0] {
        SL_CMD,
        SL_ADDR,
        SL_PROBE,
        SL_DATA,
        SL_GAP
    } slot_e;

    localparam int unsigned CMD_BITS  = 3;
    localparam logic [CMD_BITS-1:0] READ_CMD = 3'b110;
    localparam int unsigned HALF_BITS = 16;

    typedef struct packed {
        logic [HALF_BITS-1:0] hi;
        logic [HALF_BITS-1:0] lo;
    } reg_word_t;

    function automatic int unsigned slots_per_read(input int unsigned aw);
        return CMD_BITS + aw + 1 + HALF_BITS + 1;
    endfunction

    function automatic slot_e classify(input int unsigned k, input int unsigned aw);
        if (k < CMD_BITS)                        return SL_CMD;
        else if (k < CMD_BITS + aw)              return SL_ADDR;
        else if (k == CMD_BITS + aw)             return SL_PROBE;
        else if (k <= CMD_BITS + aw + HALF_BITS) return SL_DATA;
        else                                     return SL_GAP;
    endfunction

endpackage

// File: rtl/secfg_clkdiv.sv
module secfg_clkdiv #(
    parameter int unsigned DIV = 132
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic sk_hi,
    output logic smp_tick,
    output logic end_tick
);
    localparam int unsigned PH_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PH_W-1:0] PH_HALF = PH_W'(DIV / 2);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);

    logic [PH_W-1:0] ph;

    always_ff @(posedge clk) begin
        if (rst || !run)        ph <= '0;
        else if (ph == PH_LAST) ph <= '0;
        else                    ph <= ph + 1'b1;
    end

    assign sk_hi    = run && (ph >= PH_HALF);
    assign smp_tick = run && (ph == PH_HALF);
    assign end_tick = run && (ph == PH_LAST);

    AST_SK_LOW_AFTER_WRAP: assert property (@(posedge clk) disable iff (rst)
        end_tick |=> !sk_hi); // R1

endmodule

// File: rtl/secfg_reload_q.sv
module secfg_reload_q (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic take,
    output logic pend
);
    always_ff @(posedge clk) begin
        if (rst)       pend <= 1'b1;
        else if (take) pend <= req;
        else           pend <= pend | req;
    end

    AST_REQ_KEPT: assert property (@(posedge clk) disable iff (rst)
        (req && !take) |=> pend); // R3

endmodule

// File: rtl/secfg_asm.sv
module secfg_asm
    import secfg_pkg::*;
#(
    parameter int unsigned IW = 6,
    parameter int unsigned WW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          shift_en,
    input  logic          din,
    input  logic          word_end,
    input  logic          chk33,
    input  logic [WW-1:0] word_idx,
    output logic          sh_lsb,
    output logic          is_blank,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output logic [31:0]   wr_data
);
    logic [HALF_BITS-1:0] sh;
    logic [HALF_BITS-1:0] hi;
    reg_word_t            hold;
    reg_word_t            cur;

    assign cur      = '{hi: hi, lo: sh};
    assign sh_lsb   = sh[0];
    assign is_blank = (hold == '1) && sh[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            sh      <= '0;
            hi      <= '0;
            hold    <= '0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (shift_en) sh <= {sh[HALF_BITS-2:0], din};
            if (word_end) begin
                if (!word_idx[0]) begin
                    hi <= sh;
                end else if (word_idx == WW'(1)) begin
                    hold <= cur;
                end else begin
                    wr_en   <= 1'b1;
                    wr_idx  <= IW'(word_idx >> 1);
                    wr_data <= cur;
                end
            end
            if (chk33 && !is_blank) begin
                wr_en   <= 1'b1;
                wr_idx  <= '0;
                wr_data <= hold;
            end
        end
    end

    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en); // R9

endmodule

// File: rtl/secfg_loader.sv
module secfg_loader
    import secfg_pkg::*;
#(
    parameter int unsigned DIV  = 132,
    parameter int unsigned AW   = 8,
    parameter int unsigned NREG = 34
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                reload_req,
    input  logic                                ee_di,
    output logic                                ee_cs,
    output logic                                ee_sk,
    output logic                                ee_do,
    output logic                                cfg_wr_en,
    output logic [((NREG>1)?$clog2(NREG):1)-1:0] cfg_wr_idx,
    output logic [31:0]                         cfg_wr_data,
    output logic                                busy,
    output logic                                cfg_valid
);
    localparam int unsigned IW      = (NREG > 1) ? $clog2(NREG) : 1;
    localparam int unsigned WW      = $clog2(2 * NREG);
    localparam int unsigned NSLOT   = slots_per_read(AW);
    localparam int unsigned K_W     = $clog2(NSLOT);
    localparam int          CB      = CMD_BITS;
    localparam logic [K_W-1:0] K_PROBE = K_W'(CMD_BITS + AW);
    localparam logic [K_W-1:0] K_DATA0 = K_W'(CMD_BITS + AW + 1);
    localparam logic [K_W-1:0] K_DLAST = K_W'(CMD_BITS + AW + HALF_BITS);
    localparam logic [K_W-1:0] K_GAP   = K_W'(NSLOT - 1);
    localparam logic [WW-1:0]  W_LAST  = WW'(2 * NREG - 1);

    ld_state_e      st;
    logic [K_W-1:0] k;
    logic [WW-1:0]  w;
    logic           valid_q;
    logic           run, start, pend;
    logic           sk_hi, smp_tick, end_tick;
    logic           shift_en, word_end, chk33;
    logic           sh_lsb, is_blank, absent_hit, blank_hit;
    logic [AW-1:0]  ee_addr;
    slot_e          kind;
    logic           do_bit;

    assign run   = (st == LD_RUN);
    assign start = (st == LD_IDLE) && pend;

    secfg_clkdiv #(.DIV(DIV)) clkdiv_i (
        .clk(clk), .rst(rst), .run(run),
        .sk_hi(sk_hi), .smp_tick(smp_tick), .end_tick(end_tick)
    );

    secfg_reload_q reload_q_i (
        .clk(clk), .rst(rst), .req(reload_req), .take(start), .pend(pend)
    );

    always_comb begin
        int kk;
        kk     = int'(k);
        kind   = classify(kk, AW);
        do_bit = 1'b0;
        if (kind == SL_CMD)       do_bit = READ_CMD[CB-1-kk];
        else if (kind == SL_ADDR) do_bit = ee_addr[AW-1-(kk-CB)];
    end

    assign ee_addr    = AW'(w);
    assign shift_en   = smp_tick && ((kind == SL_PROBE) || (kind == SL_DATA));
    assign word_end   = end_tick && (k == K_DLAST);
    assign chk33      = end_tick && (k == K_DATA0) && (w == WW'(2));
    assign absent_hit = end_tick && (k == K_PROBE) && (w == '0) && sh_lsb;
    assign blank_hit  = chk33 && is_blank;

    secfg_asm #(.IW(IW), .WW(WW)) asm_i (
        .clk(clk), .rst(rst), .shift_en(shift_en), .din(ee_di),
        .word_end(word_end), .chk33(chk33), .word_idx(w),
        .sh_lsb(sh_lsb), .is_blank(is_blank),
        .wr_en(cfg_wr_en), .wr_idx(cfg_wr_idx), .wr_data(cfg_wr_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= LD_IDLE;
            k       <= '0;
            w       <= '0;
            valid_q <= 1'b0;
        end else if (start) begin
            st      <= LD_RUN;
            k       <= '0;
            w       <= '0;
            valid_q <= 1'b0;
        end else if (run && end_tick) begin
            if (absent_hit || blank_hit) begin
                st <= LD_IDLE;
            end else if (k == K_GAP) begin
                if (w == W_LAST) begin
                    st <= LD_IDLE;
                end else begin
                    w <= w + 1'b1;
                    k <= '0;
                end
            end else begin
                k <= k + 1'b1;
            end
            if (chk33 && !is_blank) valid_q <= 1'b1;
        end
    end

    assign ee_cs     = run && (kind != SL_GAP);
    assign ee_sk     = sk_hi && (kind != SL_GAP);
    assign ee_do     = run && do_bit;
    assign busy      = run;
    assign cfg_valid = valid_q;

    AST_WR_IN_LOAD: assert property (@(posedge clk) disable iff (rst)
        cfg_wr_en |-> busy); // R9
    AST_WR_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        cfg_wr_en |-> cfg_valid); // R8
    AST_WR_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        cfg_wr_en |-> (int'(cfg_wr_idx) < NREG)); // R9
    AST_LINES_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!ee_cs && !ee_sk && !ee_do)); // R5
    AST_VALID_CLEARED: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !cfg_valid); // R10

endmodule

// File: tb/secfg_loader_tb.sv
module secfg_loader_tb_top;
    localparam int DIV   = 4;
    localparam int AW    = 8;
    localparam int NREG  = 34;
    localparam int IW    = $clog2(NREG);
    localparam int NW    = 2 * NREG;
    localparam int NSLOT = AW + 21;
    localparam int FULL_LEN   = NW * NSLOT * DIV;
    localparam int ABSENT_LEN = (AW + 4) * DIV;
    localparam int BLANK_LEN  = (2 * NSLOT + AW + 5) * DIV;
    localparam int WD_LIMIT   = 150000;

    logic          clk = 1'b0;
    logic          rst;
    logic          reload_req;
    logic          ee_di = 1'b1;
    logic          ee_cs, ee_sk, ee_do;
    logic          cfg_wr_en;
    logic [IW-1:0] cfg_wr_idx;
    logic [31:0]   cfg_wr_data;
    logic          busy, cfg_valid;

    always #5 clk = ~clk;

    secfg_loader #(.DIV(DIV), .AW(AW), .NREG(NREG)) dut_i (
        .clk(clk), .rst(rst), .reload_req(reload_req), .ee_di(ee_di),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_do(ee_do),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx), .cfg_wr_data(cfg_wr_data),
        .busy(busy), .cfg_valid(cfg_valid)
    );

    logic [15:0] mem [0:NW-1];
    bit          mode_absent = 1'b0;

    // EEPROM model
    int          rcnt = 0;
    int          txn = 0;
    int          cmd_err = 0;
    logic [31:0] rx = '0;
    logic        d_cs = 1'b0, d_sk = 1'b0, d_busy = 1'b0;

    always @(ee_cs or ee_sk or busy) begin
        if (busy && !d_busy) txn = 0;
        if (ee_cs && !d_cs) begin
            rcnt = 0; rx = '0; ee_di = 1'b1;
        end else if (!ee_cs && d_cs) begin
            if (rx[AW+2:AW] != 3'b110 || rx[AW-1:0] != txn[AW-1:0]) cmd_err++;
            txn++;
            ee_di = 1'b1;
        end else if (ee_cs && ee_sk && !d_sk) begin
            if (rcnt < AW + 3) rx = {rx[30:0], ee_do};
            rcnt++;
        end else if (ee_cs && !ee_sk && d_sk) begin
            if (mode_absent) ee_di = 1'b1;
            else if (rcnt == AW + 3) ee_di = 1'b0;
            else if (rcnt > AW + 3 && rcnt <= AW + 19 && int'(rx[AW-1:0]) < NW)
                ee_di = mem[int'(rx[AW-1:0])][15 - (rcnt - (AW + 4))];
            else ee_di = 1'b1;
        end
        d_cs = ee_cs; d_sk = ee_sk; d_busy = busy;
    end

    // Port monitor, sampled on the falling clock edge
    int          wr_cnt = 0, order_err = 0, busy_len = 0, loads = 0;
    int          idle_run = 0, last_idle = 0, gap = 0, gap_err = 0;
    int          hi_len = 0, per = 0, sk_err = 0, do_err = 0;
    bit          per_ok = 1'b0;
    logic        p_busy = 1'b0, p_cs = 1'b0, p_sk = 1'b0, p_do = 1'b0;
    logic [31:0] got [0:NREG-1];

    always @(negedge clk) begin
        if (busy && !p_busy) begin loads++; last_idle = idle_run; idle_run = 0; end
        if (busy) busy_len++; else idle_run++;
        if (cfg_wr_en) begin
            if (int'(cfg_wr_idx) != wr_cnt % NREG) order_err++;
            if (int'(cfg_wr_idx) < NREG) got[cfg_wr_idx] = cfg_wr_data;
            wr_cnt++;
        end
        if (busy && !ee_cs) gap++;
        if (ee_cs && !p_cs) begin
            if (gap != 0 && gap != DIV) gap_err++;
            gap = 0; per_ok = 1'b0;
        end
        if (ee_sk) hi_len++;
        if (!ee_sk && p_sk) begin
            if (hi_len != DIV / 2) sk_err++;
            hi_len = 0;
        end
        if (ee_sk && !p_sk) begin
            if (per_ok && per != DIV - 1) sk_err++;
            per = 0; per_ok = 1'b1;
        end else per++;
        if (ee_sk && p_sk && ee_do != p_do) do_err++;
        p_busy = busy; p_cs = ee_cs; p_sk = ee_sk; p_do = ee_do;
    end

    int checks = 0, failures = 0;
    int b_wr, b_ord, b_len, b_loads, b_gap, b_sk, b_do, b_cmd;

    initial begin
        repeat (WD_LIMIT) @(negedge clk);
        $display("FAIL watchdog: run did not finish, actual=%0d cycles expected<%0d", WD_LIMIT, WD_LIMIT);
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic snap();
        b_wr = wr_cnt; b_ord = order_err; b_len = busy_len; b_loads = loads;
        b_gap = gap_err; b_sk = sk_err; b_do = do_err; b_cmd = cmd_err;
    endtask

    task automatic fill(input int s);
        for (int i = 0; i < NW; i++) mem[i] = 16'(i * 613 + s * 4099 + 29);
    endtask

    task automatic pulse_reload();
        @(negedge clk) reload_req = 1'b1;
        @(negedge clk) reload_req = 1'b0;
    endtask

    task automatic wait_done();
        bit seen = 1'b0;
        for (int n = 0; n < 40000; n++) begin
            @(negedge clk);
            if (busy) seen = 1'b1;
            else if (seen) break;
        end
        @(negedge clk);
    endtask

    task automatic check_serial(input string tag);
        chk(cmd_err == b_cmd, {tag, " R4 command/address"}, cmd_err - b_cmd, 0);
        chk(gap_err == b_gap, {tag, " R5 cs gap"}, gap_err - b_gap, 0);
        chk(sk_err == b_sk, {tag, " R1 sk timing"}, sk_err - b_sk, 0);
        chk(do_err == b_do, {tag, " R1 do stable"}, do_err - b_do, 0);
    endtask

    task automatic check_image(input string req);
        for (int i = 0; i < NREG; i++)
            chk(got[i] == {mem[2*i], mem[2*i+1]}, req, got[i], {mem[2*i], mem[2*i+1]});
    endtask

    task automatic check_full(input string tag);
        chk(wr_cnt - b_wr == NREG, {tag, " R8 write count"}, wr_cnt - b_wr, NREG);
        chk(order_err == b_ord, {tag, " R8 index order"}, order_err - b_ord, 0);
        check_image({tag, " R8 register data"});
        chk(cfg_valid == 1'b1, {tag, " R8 valid"}, cfg_valid, 1);
        chk(busy_len - b_len == FULL_LEN, {tag, " R10 load length"}, busy_len - b_len, FULL_LEN);
        check_serial(tag);
    endtask

    initial begin
        rst = 1'b1; reload_req = 1'b0;
        for (int i = 0; i < NREG; i++) got[i] = '0;
        fill(1);
        repeat (5) @(negedge clk);
        chk(busy == 1'b0, "R2 reset busy", busy, 0);
        chk(ee_cs == 1'b0 && ee_sk == 1'b0, "R2 reset lines", {ee_cs, ee_sk}, 0);
        chk(cfg_wr_en == 1'b0, "R2 reset strobe", cfg_wr_en, 0);
        chk(cfg_valid == 1'b0, "R2 reset valid", cfg_valid, 0);
        snap();
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b1, "R2 auto start", busy, 1);
        wait_done();
        check_full("auto");

        // no spontaneous load
        snap();
        repeat (300) @(negedge clk);
        chk(loads == b_loads && busy == 1'b0, "R3 no load without request", loads - b_loads, 0);

        // idle reload starts two clocks after the pulse
        mode_absent = 1'b1;
        snap();
        @(negedge clk) reload_req = 1'b1;
        @(negedge clk) reload_req = 1'b0;
        chk(busy == 1'b0, "R3 not yet started", busy, 0);
        @(negedge clk);
        chk(busy == 1'b1, "R3 started", busy, 1);
        chk(cfg_valid == 1'b0, "R10 valid cleared at start", cfg_valid, 0);
        wait_done();
        chk(busy_len - b_len == ABSENT_LEN, "R6 absent length", busy_len - b_len, ABSENT_LEN);
        chk(busy_len - b_len <= 13 * DIV, "R6 within 13 periods", busy_len - b_len, 13 * DIV);
        chk(wr_cnt == b_wr, "R6 no writes", wr_cnt - b_wr, 0);
        chk(cfg_valid == 1'b0, "R6 valid low", cfg_valid, 0);
        check_serial("absent");
        mode_absent = 1'b0;

        // second programmed image
        fill(2);
        snap();
        pulse_reload();
        wait_done();
        check_full("prog2");

        // fully blank device
        for (int i = 0; i < NW; i++) mem[i] = 16'hFFFF;
        snap();
        pulse_reload();
        wait_done();
        chk(wr_cnt == b_wr, "R7 blank no writes", wr_cnt - b_wr, 0);
        chk(cfg_valid == 1'b0, "R7 blank valid", cfg_valid, 0);
        chk(busy_len - b_len == BLANK_LEN, "R7 blank length", busy_len - b_len, BLANK_LEN);
        check_serial("blank");

        // 33 ones followed by programmed data: still blank
        fill(3);
        mem[0] = 16'hFFFF; mem[1] = 16'hFFFF; mem[2] = 16'hFFFF;
        snap();
        pulse_reload();
        wait_done();
        chk(wr_cnt == b_wr, "R7 33-ones no writes", wr_cnt - b_wr, 0);
        chk(cfg_valid == 1'b0, "R7 33-ones valid", cfg_valid, 0);
        chk(busy_len - b_len == BLANK_LEN, "R7 33-ones length", busy_len - b_len, BLANK_LEN);

        // 32 ones then a zero: programmed
        fill(4);
        mem[0] = 16'hFFFF; mem[1] = 16'hFFFF; mem[2] = 16'h7FFF;
        snap();
        pulse_reload();
        wait_done();
        check_full("R11 near-blank");
        chk(got[0] == 32'hFFFF_FFFF, "R11 reg0 all ones", got[0], 32'hFFFF_FFFF);

        // reload requested during a load
        fill(5);
        snap();
        pulse_reload();
        repeat (500) @(negedge clk);
        pulse_reload();
        for (int n = 0; n < 40000 && loads < b_loads + 2; n++) @(negedge clk);
        chk(loads == b_loads + 2, "R3 queued load started", loads - b_loads, 2);
        chk(last_idle == 1, "R3 one idle cycle between loads", last_idle, 1);
        wait_done();
        chk(wr_cnt - b_wr == 2 * NREG, "R3 two loads of writes", wr_cnt - b_wr, 2 * NREG);
        chk(order_err == b_ord, "R3 order across loads", order_err - b_ord, 0);
        check_image("R3 queued load data");
        chk(busy_len - b_len == 2 * FULL_LEN, "R3 total busy", busy_len - b_len, 2 * FULL_LEN);
        repeat (100) @(negedge clk);
        chk(loads == b_loads + 2, "R3 no third load", loads - b_loads, 2);
        check_serial("queued");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule